// File: doc/BRIEF.md
# Saturating Serial Pulse Counter

This block watches a single-bit serial line, sampled on every rising clock edge, and counts complete pulses on it. A pulse is a run of one or more low samples, then one or more high samples, then a low sample. The count is advanced on the edge that samples the closing low, so a high level that never returns low is not counted.

When the block leaves reset it assumes the line has been high. A high level seen before the first low therefore does not start a pulse. The counter holds up to 2^CNT_W - 1 pulses. The pulse after that drives the block into a locked fault state: the count freezes at its maximum and the fault flag stays high until the next synchronous reset.

A small control machine tracks where the line is in the pulse pattern, and a separate register holds the count. The fault flag is decoded from the control state.

Top module: `pulse_tally`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to its initial state. After that edge `count` is 0 and `fault` is 0.
- R2: From the initial state, any number of high samples leaves `count` unchanged. The first low sample moves the block to the between-pulses state, still without counting.
- R3: In the between-pulses state, a high sample moves the block inside a pulse. The next low sample increments `count` by exactly 1, and the new value is visible after that rising edge.
- R4: Every phase of a pulse may last a single clock cycle. The alternating samples 0,1,0,1,0 from the between-pulses state add one count for each return to low.
- R5: A high level held for many cycles inside a pulse, and a low level held for many cycles between pulses, leave `count` unchanged.
- R6: Exactly 2^CNT_W - 1 complete pulses (15 with the default CNT_W=4) give `count` = 15 with `fault` still 0.
- R7: A pulse that completes while `count` already equals its maximum sets `fault` to 1 after that edge. `count` stays at the maximum.
- R8: Once `fault` is 1, only reset clears it. Further pulses change neither `fault` nor `count`.
- R9: `fault` is 1 exactly when the control machine is in the locked state. After a reset out of that state, counting starts again from 0 with the initial-state rule of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial line being watched |
| count | output | CNT_W (4) | Number of complete pulses seen, registered |
| fault | output | 1 | High while locked after an overflowing pulse |

## Verification
A long high preamble right after reset shows whether a leading high is wrongly taken as the start of a pulse. Single-cycle alternation separates a machine that needs a settled level from one that counts every phase change. Long-held highs and lows show whether a count is taken more than once per pulse. A run of exactly fifteen pulses, then a sixteenth, then more pulses tells apart a counter that saturates and locks from one that wraps or overflows early. A reset out of the locked state confirms that the initial rule applies again.

// File: rtl/pulse_tally_pkg.sv
package pulse_tally_pkg;

    localparam int PT_CNT_W_DEF = 4;

    typedef enum logic [1:0] {
        PT_ARMED  = 2'd0,   // after reset, line assumed high
        PT_GAP    = 2'd1,   // line low, waiting for a rise
        PT_HIGH   = 2'd2,   // inside a pulse
        PT_LOCKED = 2'd3    // overflow seen, frozen until reset
    } pt_state_e;

    typedef struct packed {
        pt_state_e nxt;
        logic      bump;
    } pt_step_t;

    function automatic pt_step_t pt_step(pt_state_e cur, logic line, logic full);
        pt_step_t s;
        s.nxt  = cur;
        s.bump = 1'b0;
        case (cur)
            PT_ARMED:  if (!line) s.nxt = PT_GAP;
            PT_GAP:    if (line)  s.nxt = PT_HIGH;
            PT_HIGH: begin
                if (!line) begin
                    if (full) begin
                        s.nxt = PT_LOCKED;
                    end else begin
                        s.nxt  = PT_GAP;
                        s.bump = 1'b1;
                    end
                end
            end
            default:   s.nxt = PT_LOCKED;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pulse_tally_ctrl.sv
module pulse_tally_ctrl
    import pulse_tally_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    input  logic      full,
    output logic      bump,
    output pt_state_e state
);

    pt_step_t step;

    always_comb begin
        step = pt_step(state, din, full);
        bump = step.bump;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PT_ARMED;
        else     state <= step.nxt;
    end

    // R2: a high line in the initial state keeps it there
    assert_armed_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (state == PT_ARMED && din) |=> (state == PT_ARMED));

    // R7: closing a pulse while full must lock
    assert_lock_on_full_R7: assert property (@(posedge clk) disable iff (rst)
        (state == PT_HIGH && !din && full) |=> (state == PT_LOCKED));

    // R8: the locked state has no exit but reset
    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (state == PT_LOCKED) |=> (state == PT_LOCKED));

endmodule

// File: rtl/pulse_tally_count.sv
module pulse_tally_count #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [CNT_W-1:0] cnt,
    output logic             full
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assign full = (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (bump && !full) cnt <= cnt + 1'b1;
    end

    // R3: each accepted pulse adds exactly one
    assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
        bump |=> (cnt == $past(cnt) + 1'b1));

    // R5: no accepted pulse, no change
    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !bump |=> $stable(cnt));

    // R7: the counter must never be asked to pass its ceiling
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        full |-> !bump);

endmodule

// File: rtl/pulse_tally.sv
module pulse_tally
    import pulse_tally_pkg::*;
#(
    parameter int CNT_W = PT_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic [CNT_W-1:0] count,
    output logic             fault
);

    pt_state_e state;
    logic      bump;
    logic      full;

    pulse_tally_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .din   (din),
        .full  (full),
        .bump  (bump),
        .state (state)
    );

    pulse_tally_count #(.CNT_W(CNT_W)) u_count (
        .clk  (clk),
        .rst  (rst),
        .bump (bump),
        .cnt  (count),
        .full (full)
    );

    assign fault = (state == PT_LOCKED);

    // R9: a fault flag implies a saturated count
    assert_fault_full_R9: assert property (@(posedge clk) disable iff (rst)
        fault |-> full);

    // R1: a reset edge leaves a clean count and no fault
    assert_reset_clean_R1: assert property (@(posedge clk)
        rst |=> (count == '0 && !fault));

endmodule

// File: tb/pulse_tally_tb_top.sv
module pulse_tally_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b1;
    logic [3:0] count;
    logic       fault;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    pulse_tally dut_i (
        .clk   (clk),
        .rst   (rst),
        .din   (din),
        .count (count),
        .fault (fault)
    );

    // {din, expected fault, expected count}, applied one per cycle after reset
    localparam int NV = 16;
    localparam logic [5:0] VEC [NV] = '{
        {1'b1, 1'b0, 4'd0}, {1'b1, 1'b0, 4'd0}, {1'b1, 1'b0, 4'd0},
        {1'b0, 1'b0, 4'd0}, {1'b1, 1'b0, 4'd0}, {1'b1, 1'b0, 4'd0},
        {1'b0, 1'b0, 4'd1}, {1'b0, 1'b0, 4'd1}, {1'b1, 1'b0, 4'd1},
        {1'b0, 1'b0, 4'd2}, {1'b1, 1'b0, 4'd2}, {1'b0, 1'b0, 4'd3},
        {1'b1, 1'b0, 4'd3}, {1'b1, 1'b0, 4'd3}, {1'b1, 1'b0, 4'd3},
        {1'b0, 1'b0, 4'd4}
    };

    task automatic check(input string req, input logic [3:0] ec, input logic ef);
        checks++;
        if (count !== ec || fault !== ef) begin
            failures++;
            $display("FAIL %s: count=%0d fault=%0b expected count=%0d fault=%0b",
                     req, count, fault, ec, ef);
        end
    endtask

    // drive on the falling edge, sample just after the next rising edge
    task automatic step(input logic v);
        @(negedge clk);
        din = v;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: count=%0d fault=%0b expected run to end", count, fault);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(1'b1);
        step(1'b1);
        check("R1", 4'd0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // table walk: preamble (R2), first pulse (R3), single-cycle phases (R4), long levels (R5)
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][5]);
            check(i < 4 ? "R2" : (i < 8 ? "R3" : (i < 12 ? "R4" : "R5")),
                  VEC[i][3:0], VEC[i][4]);
        end

        // R6: bring the count to exactly 15 with single-cycle pulses
        for (int k = 0; k < 11; k++) begin
            step(1'b1);
            step(1'b0);
        end
        check("R6", 4'd15, 1'b0);
        step(1'b1);
        check("R6", 4'd15, 1'b0);

        // R7: the 16th return to low locks
        step(1'b0);
        check("R7", 4'd15, 1'b1);

        // R8: more pulses have no effect
        for (int k = 0; k < 3; k++) begin
            step(1'b1);
            step(1'b1);
            step(1'b0);
            check("R8", 4'd15, 1'b1);
        end

        // R9 / R1: reset out of the locked state
        @(negedge clk);
        rst = 1'b1;
        din = 1'b1;
        @(posedge clk);
        #1;
        check("R1", 4'd0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        step(1'b1);
        step(1'b1);
        check("R9", 4'd0, 1'b0);
        step(1'b0);
        check("R9", 4'd0, 1'b0);
        step(1'b1);
        step(1'b0);
        check("R9", 4'd1, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule